// File: doc/BRIEF.md
# Echo Replay Fetch Sequencer

This block owns the program counter of a small in-order core whose instruction set has an echo instruction. An echo carries a byte offset and an instruction count. When it issues, fetch jumps back by the offset to an earlier copy of a code run. Exactly the requested number of instructions are fetched from there in sequence. Fetch then resumes at the instruction that follows the echo. The return address sits in a hidden register, so the echo needs no call, no return instruction, no stack frame and no parameters.

The decoder presents the instruction at `fetch_pc` in the same cycle, and that instruction issues in every cycle where `stall` is low. There is no data stream through the block. `stall` is the only back-pressure and all other pins are plain level controls. A low `stall` means the instruction at `fetch_pc` is consumed at the next rising edge. A high `stall` holds every piece of state. Instructions are 4 bytes wide and addresses count bytes. For example, an echo at 340 with offset 240 and count 5 fetches 100, 104, 108, 112 and 116, then 344. An echo issued while a replay is running is not nested. A taken branch inside a replay leaves the replay.

Top module: `echo_fetch_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is `fetch_pc` = RESET_VEC with `echo_active`, `echo_fault` and `nest_fault` all low. This applies even in the middle of a replay.
- R2: Outside a replay, a non-stalled issue moves `fetch_pc` to `fetch_pc`+4, or to `dec_target` when `dec_taken` is high.
- R3: A non-stalled echo outside a replay, with nonzero count and a valid offset, makes the next `fetch_pc` equal the echo address minus `dec_offset` and raises `echo_active`.
- R4: After an accepted echo with count N, exactly N non-stalled issues occur at consecutive word addresses with `echo_active` high. The next `fetch_pc` is then the echo address + 4, with `echo_active` low.
- R5: An echo with `dec_length` = 0 acts as a plain instruction. Fetch goes to the echo address + 4, with no replay and no fault, whatever the offset is.
- R6: An offset is invalid when it is zero, when its two low bits are not 00, or when it is larger than the echo address. An echo with nonzero count and an invalid offset pulses `echo_fault` high for the one cycle after its issue, and fetch goes to the echo address + 4 without a replay.
- R7: An echo issued during a replay pulses `nest_fault` for one cycle. It otherwise counts as one ordinary replayed instruction, and the replay length and return address stay unchanged.
- R8: A taken branch during a replay moves fetch to `dec_target` and drops `echo_active`. The saved return address is then never used.
- R9: While `stall` is high, `fetch_pc`, `echo_active` and the remaining replay count hold, every decode input is ignored, and both fault outputs are low in the following cycle.
- R10: When `dec_taken` and `dec_echo` are both high, the branch wins. Fetch goes to `dec_target` and no replay starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | High: nothing issues this cycle |
| dec_echo | input | 1 | The instruction at `fetch_pc` is an echo |
| dec_offset | input | ADDR_W | Echo backward distance in bytes |
| dec_length | input | LEN_W | Echo replay count in instructions |
| dec_taken | input | 1 | The instruction at `fetch_pc` is a taken branch or jump |
| dec_target | input | ADDR_W | Branch or jump destination |
| fetch_pc | output | ADDR_W | Address of the instruction being issued |
| echo_active | output | 1 | `fetch_pc` lies inside a replay |
| echo_fault | output | 1 | One-cycle pulse: an echo was rejected for its offset |
| nest_fault | output | 1 | One-cycle pulse: an echo arrived during a replay |

## Verification
A wrong remaining count shows at the ports only when the replay ends, as a return that comes one or more fetches early or late. The bench therefore sweeps every count from 0 to 5 against several offsets and compares each replayed address and the return address. A corrupted return register appears only on the first fetch after the last replayed instruction. A counter that moves during a stall appears as a shortened replay once the stall is released. For that reason the stall, nested-echo and cancel cases each follow the replay through to its end.

// File: rtl/echo_seq_pkg.sv
package echo_seq_pkg;

  localparam int unsigned INSN_BYTES = 4;

  typedef enum logic [2:0] {
    NPC_HOLD,
    NPC_SEQ,
    NPC_BRANCH,
    NPC_ECHO,
    NPC_RETURN
  } npc_sel_e;

endpackage

// File: rtl/echo_addr_check.sv
module echo_addr_check #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8
) (
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] offset,
  input  logic [LEN_W-1:0]  length,
  output logic [ADDR_W-1:0] replay_base,
  output logic              empty_run,
  output logic              bad_offset
);

  localparam int unsigned ALIGN_W = $clog2(echo_seq_pkg::INSN_BYTES);

  logic misaligned;
  logic zero_dist;
  logic underflow;

  always_comb begin
    misaligned  = offset[ALIGN_W-1:0] != '0;
    zero_dist   = offset == '0;
    underflow   = offset > cur_pc;
    bad_offset  = misaligned | zero_dist | underflow;
    empty_run   = length == '0;
    replay_base = cur_pc - offset;
  end

endmodule

// File: rtl/echo_replay_ctrl.sv
module echo_replay_ctrl #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              start,
  input  logic              cancel,
  input  logic [LEN_W-1:0]  length,
  input  logic [ADDR_W-1:0] resume_addr,
  output logic              active,
  output logic              final_slot,
  output logic [ADDR_W-1:0] ret_addr
);

  logic [LEN_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      remain_q <= '0;
      ret_addr <= '0;
    end else if (issue) begin
      if (start) begin
        active   <= 1'b1;
        remain_q <= length;
        ret_addr <= resume_addr;
      end else if (active) begin
        if (cancel) begin
          active   <= 1'b0;
          remain_q <= '0;
          ret_addr <= '0;
        end else if (remain_q == LEN_W'(1)) begin
          active   <= 1'b0;
          remain_q <= '0;
        end else begin
          remain_q <= remain_q - LEN_W'(1);
        end
      end
    end
  end

  assign final_slot = active && (remain_q == LEN_W'(1));

endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
  import echo_seq_pkg::*;
#(
  parameter int unsigned    ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  npc_sel_e          sel,
  input  logic [ADDR_W-1:0] branch_tgt,
  input  logic [ADDR_W-1:0] echo_tgt,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] pc_next_seq
);

  logic [ADDR_W-1:0] npc;

  assign pc_next_seq = pc + ADDR_W'(INSN_BYTES);

  always_comb begin
    case (sel)
      NPC_SEQ:    npc = pc_next_seq;
      NPC_BRANCH: npc = branch_tgt;
      NPC_ECHO:   npc = echo_tgt;
      NPC_RETURN: npc = ret_addr;
      default:    npc = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= RESET_VEC;
    else        pc <= npc;
  end

endmodule

// File: rtl/echo_fetch_seq.sv
module echo_fetch_seq
  import echo_seq_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       LEN_W     = 8,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              dec_echo,
  input  logic [ADDR_W-1:0] dec_offset,
  input  logic [LEN_W-1:0]  dec_length,
  input  logic              dec_taken,
  input  logic [ADDR_W-1:0] dec_target,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic              echo_active,
  output logic              echo_fault,
  output logic              nest_fault
);

  logic              issue;
  logic              echo_try;
  logic              start_echo;
  logic              nest_evt;
  logic              fault_evt;
  logic              last_issue;
  logic              empty_run;
  logic              bad_offset;
  logic [ADDR_W-1:0] replay_base;
  logic [ADDR_W-1:0] ret_addr;
  logic [ADDR_W-1:0] pc_plus4;
  npc_sel_e          sel;

  echo_addr_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_check (
    .cur_pc      (fetch_pc),
    .offset      (dec_offset),
    .length      (dec_length),
    .replay_base (replay_base),
    .empty_run   (empty_run),
    .bad_offset  (bad_offset)
  );

  assign issue      = ~stall;
  assign echo_try   = issue & dec_echo & ~dec_taken;
  assign start_echo = echo_try & ~echo_active & ~empty_run & ~bad_offset;
  assign nest_evt   = echo_try & echo_active;
  assign fault_evt  = echo_try & ~echo_active & ~empty_run & bad_offset;

  echo_replay_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_replay (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (issue),
    .start       (start_echo),
    .cancel      (dec_taken),
    .length      (dec_length),
    .resume_addr (pc_plus4),
    .active      (echo_active),
    .final_slot  (last_issue),
    .ret_addr    (ret_addr)
  );

  always_comb begin
    if (!issue)          sel = NPC_HOLD;
    else if (dec_taken)  sel = NPC_BRANCH;
    else if (start_echo) sel = NPC_ECHO;
    else if (last_issue) sel = NPC_RETURN;
    else                 sel = NPC_SEQ;
  end

  fetch_pc_unit #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .branch_tgt  (dec_target),
    .echo_tgt    (replay_base),
    .ret_addr    (ret_addr),
    .pc          (fetch_pc),
    .pc_next_seq (pc_plus4)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      echo_fault <= 1'b0;
      nest_fault <= 1'b0;
    end else begin
      echo_fault <= fault_evt;
      nest_fault <= nest_evt;
    end
  end

endmodule

// File: rtl/echo_fetch_seq_chk.sv
module echo_fetch_seq_chk #(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              dec_echo,
  input logic              dec_taken,
  input logic [ADDR_W-1:0] dec_offset,
  input logic [ADDR_W-1:0] dec_target,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              echo_active,
  input logic              echo_fault,
  input logic              nest_fault,
  input logic              start_echo,
  input logic              last_issue,
  input logic [ADDR_W-1:0] ret_addr
);

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (fetch_pc == RESET_VEC && !echo_active && !echo_fault && !nest_fault));

  p_redirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_echo |=> (echo_active && fetch_pc == $past(fetch_pc) - $past(dec_offset)));

  p_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && last_issue && !dec_taken) |=> (!echo_active && fetch_pc == $past(ret_addr)));

  p_nest_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && echo_active && dec_echo && !dec_taken) |=> (nest_fault && !echo_fault));

  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && echo_active && dec_taken) |=> (!echo_active && fetch_pc == $past(dec_target)));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(fetch_pc) && $stable(echo_active) && !echo_fault && !nest_fault));

  p_branch_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && dec_taken) |=> (fetch_pc == $past(dec_target) && !echo_active));

endmodule

bind echo_fetch_seq echo_fetch_seq_chk #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stall       (stall),
  .dec_echo    (dec_echo),
  .dec_taken   (dec_taken),
  .dec_offset  (dec_offset),
  .dec_target  (dec_target),
  .fetch_pc    (fetch_pc),
  .echo_active (echo_active),
  .echo_fault  (echo_fault),
  .nest_fault  (nest_fault),
  .start_echo  (start_echo),
  .last_issue  (last_issue),
  .ret_addr    (ret_addr)
);

// File: tb/echo_fetch_seq_tb.sv
module echo_fetch_seq_tb;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned LEN_W  = 8;
  localparam logic [31:0] RV     = 32'd340;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              stall;
  logic              dec_echo;
  logic [ADDR_W-1:0] dec_offset;
  logic [LEN_W-1:0]  dec_length;
  logic              dec_taken;
  logic [ADDR_W-1:0] dec_target;
  logic [ADDR_W-1:0] fetch_pc;
  logic              echo_active;
  logic              echo_fault;
  logic              nest_fault;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_pc;

  always #4 clk = ~clk;

  echo_fetch_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .RESET_VEC(RV)) u_dut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .dec_echo(dec_echo),
    .dec_offset(dec_offset), .dec_length(dec_length), .dec_taken(dec_taken),
    .dec_target(dec_target), .fetch_pc(fetch_pc), .echo_active(echo_active),
    .echo_fault(echo_fault), .nest_fault(nest_fault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    stall = 1'b0; dec_echo = 1'b0; dec_taken = 1'b0;
    dec_offset = '0; dec_length = '0; dec_target = '0;
  endtask

  task automatic drive_echo(input logic [31:0] off, input int len);
    dec_echo = 1'b1; dec_offset = off; dec_length = LEN_W'(len);
  endtask

  // Full echo: R3, R4, R5 checked at every replayed address and at the return
  task automatic do_echo(input logic [31:0] off, input int len);
    logic [31:0] base;
    base = exp_pc;
    drive_echo(off, len);
    step();
    idle();
    if (len == 0) begin
      chk("R5 zero count pc", fetch_pc, base + 4);
      chk("R5 zero count active", 32'(echo_active), 0);
      chk("R5 zero count fault", 32'(echo_fault), 0);
    end else begin
      for (int i = 0; i < len; i++) begin
        chk("R3 R4 replay pc", fetch_pc, base - off + 32'(4 * i));
        chk("R4 replay active", 32'(echo_active), 1);
        step();
      end
      chk("R4 return pc", fetch_pc, base + 4);
      chk("R4 return active", 32'(echo_active), 0);
    end
    exp_pc = base + 4;
  endtask

  task automatic do_bad(input logic [31:0] off);
    logic [31:0] base;
    base = exp_pc;
    drive_echo(off, 3);
    step();
    idle();
    chk("R6 bad offset pc", fetch_pc, base + 4);
    chk("R6 bad offset active", 32'(echo_active), 0);
    chk("R6 bad offset flag", 32'(echo_fault), 1);
    step();
    chk("R6 flag one cycle", 32'(echo_fault), 0);
    chk("R6 seq after fault", fetch_pc, base + 8);
    exp_pc = base + 8;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] base;
    rst_n = 1'b0;
    idle();
    repeat (3) step();
    chk("R1 reset pc", fetch_pc, RV);
    chk("R1 reset active", 32'(echo_active), 0);
    chk("R1 reset flags", 32'({echo_fault, nest_fault}), 0);
    rst_n = 1'b1;
    exp_pc = RV;

    // Worked example: echo at 340, offset 240, count 5
    do_echo(32'd240, 5);

    // R2 ordinary sequential and taken flow
    step();
    chk("R2 sequential", fetch_pc, exp_pc + 4);
    exp_pc = exp_pc + 4;
    dec_taken = 1'b1; dec_target = 32'd2048;
    step(); idle();
    chk("R2 taken branch", fetch_pc, 32'd2048);
    step();
    chk("R2 after branch", fetch_pc, 32'd2052);
    exp_pc = 32'd2052;

    // Sweep of offsets and counts
    for (int k = 1; k <= 6; k++)
      for (int len = 0; len <= 5; len++)
        do_echo(32'(4 * k), len);

    // Offset equal to the echo address lands on zero
    do_echo(exp_pc, 2);

    // R6 invalid offsets
    do_bad(32'd0);
    do_bad(32'd6);
    do_bad(32'd2);
    do_bad(exp_pc + 4);

    // R5 zero count with a bad offset raises nothing
    base = exp_pc;
    drive_echo(32'd6, 0);
    step(); idle();
    chk("R5 zero count bad offset pc", fetch_pc, base + 4);
    chk("R5 zero count bad offset flag", 32'(echo_fault), 0);
    exp_pc = base + 4;

    // R10 branch beats echo
    drive_echo(32'd8, 3); dec_taken = 1'b1; dec_target = 32'd4096;
    step(); idle();
    chk("R10 branch wins pc", fetch_pc, 32'd4096);
    chk("R10 no replay", 32'(echo_active), 0);
    exp_pc = 32'd4096;

    // R8 branch inside a replay
    base = exp_pc;
    drive_echo(32'd16, 4);
    step(); idle();
    step();
    chk("R8 second replay pc", fetch_pc, base - 12);
    dec_taken = 1'b1; dec_target = 32'd8192;
    step(); idle();
    chk("R8 cancel pc", fetch_pc, 32'd8192);
    chk("R8 cancel active", 32'(echo_active), 0);
    step();
    chk("R8 return discarded", fetch_pc, 32'd8196);
    exp_pc = 32'd8196;

    // R7 echo inside a replay
    base = exp_pc;
    drive_echo(32'd8, 3);
    step(); idle();
    drive_echo(32'd4, 2);
    step(); idle();
    chk("R7 nest flag", 32'(nest_fault), 1);
    chk("R7 no offset flag", 32'(echo_fault), 0);
    chk("R7 replay continues", fetch_pc, base - 4);
    chk("R7 still active", 32'(echo_active), 1);
    step();
    chk("R7 flag one cycle", 32'(nest_fault), 0);
    chk("R7 third slot", fetch_pc, base);
    step();
    chk("R7 original return", fetch_pc, base + 4);
    chk("R7 replay ended", 32'(echo_active), 0);
    exp_pc = base + 4;

    // R9 stall inside a replay, with a branch presented that must be ignored
    base = exp_pc;
    drive_echo(32'd20, 3);
    step(); idle();
    step();
    stall = 1'b1; dec_taken = 1'b1; dec_target = 32'd9000;
    for (int s = 0; s < 3; s++) begin
      step();
      chk("R9 stall pc", fetch_pc, base - 16);
      chk("R9 stall active", 32'(echo_active), 1);
    end
    idle();
    step();
    chk("R9 count kept pc", fetch_pc, base - 12);
    step();
    chk("R9 count kept return", fetch_pc, base + 4);
    exp_pc = base + 4;

    // R9 stalled echo does nothing
    stall = 1'b1; drive_echo(32'd4, 2);
    step();
    chk("R9 stalled echo pc", fetch_pc, exp_pc);
    chk("R9 stalled echo active", 32'(echo_active), 0);
    idle();

    // R1 reset in the middle of a replay
    drive_echo(32'd8, 4);
    step(); idle();
    step();
    rst_n = 1'b0;
    step();
    chk("R1 mid replay reset pc", fetch_pc, RV);
    chk("R1 mid replay reset active", 32'(echo_active), 0);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule